// File: doc/BRIEF.md
# Two-Wire Register-Access Target for Dual Tap Selectors

This block is the target side of a two-wire serial bus (I2C) for a register file. The file has one 8-bit register per tap selector and one control register. It runs from a fast system clock. SCL and SDA are synchronised and filtered. Bus events are recovered from edges of the filtered lines, and SDA is driven through an open-drain pull-low output. A controller addresses the block with an identification byte. The low three address bits of that byte come from strapping inputs.

A write is a START, the identification byte with the direction bit clear, an address byte, then one or more data bytes and a STOP. Each data byte is stored on the ninth clock of that byte. Extra data bytes step to the next tap selector register. A read sets the pointer with a write header. The controller then sends a repeated START and the identification byte with the direction bit set. The block returns bytes until the controller answers one with a NACK. The register outputs drive the tap selector wipers and the shared control flag.

Top module: `tap_reg_i2c_target`

## Requirements
- R1: After reset, every tap register and the control register read 40h, and the SDA pull output is inactive.
- R2: An identification byte is accepted only when its bits [7:4] are 1010 and its bits [3:1] equal strap_i[2:0]. Bit [0] selects the direction (1 = read, 0 = write). A byte that does not match gets no ACK, and every later byte is ignored until the next START.
- R3: For a write, the data byte is stored in the register that the address byte selects. The register output shows the new value while SCL is still high on the ninth clock of that data byte. No register changes at any other time.
- R4: The target ACKs an accepted identification byte, every address byte and every write data byte by pulling SDA low for the ninth clock. It starts pulling SDA only while SCL is low.
- R5: Tap registers sit at addresses 0 to NUM_WIPERS-1. Each further data byte in a write steps the pointer by one, and the pointer wraps from NUM_WIPERS-1 back to 0. The pointer does not move when it holds any other address.
- R6: The control register sits at address 10h. Only its bit 6 can be written, and its other bits always read 0.
- R7: A write to an address outside the map is ACKed and discarded. A read from such an address returns 00h.
- R8: After an address write, a repeated START and an accepted identification byte in read mode return the addressed register MSB first. Each byte that the controller ACKs is followed by the next register, stepped as in R5. After a NACK the target releases SDA.
- R9: A pulse shorter than FILT_CYCLES system clocks on SCL or on SDA has no effect.
- R10: After a STOP, bytes clocked without a new START get no ACK and change nothing.
- R11: A START that arrives within BOOT_CYCLES clocks of reset release is ignored, and so is the transfer that follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| strap_i | input | 3 | Strapped low address bits of the identification byte |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release it |
| wiper_o | output | NUM_WIPERS*8 | Tap registers, register n in bits [8n+7:8n] |
| ctrl_o | output | 8 | Control register (only bit 6 can be nonzero) |

## Verification
The bench checks single writes to each tap register. A run of data bytes that wraps from the last tap register back to the first shows the pointer stepping apart from plain repeated writes. Writes of FFh and 00h to the control register show the write mask, and an access to an unmapped address shows the discard path. Random and sequential reads with controller ACK and NACK check pointer stepping and the release of SDA. Identification bytes with a wrong strap and with a wrong prefix, bytes clocked without a START, and a START sent during boot each need their own ignore path. Short glitches on SCL and on SDA during otherwise valid transfers would each add a bit or raise a false START if the filter let them through.

// File: rtl/tapreg_pkg.sv
`timescale 1ns/1ps
package tapreg_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ID,
      PH_ADDR,
      PH_WRITE,
      PH_READ
   } phase_e;

   localparam logic [3:0] ID_PREFIX = 4'b1010;
endpackage

// File: rtl/tr_line_filter.sv
`timescale 1ns/1ps
module tr_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic clean_o
);
   localparam int CW = $clog2(FILT_CYCLES + 1);

   initial assert (SYNC_STAGES >= 1 && FILT_CYCLES >= 1)
      else $error("tr_line_filter: SYNC_STAGES and FILT_CYCLES must be at least 1");

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;
   logic [CW-1:0]          cnt_q;
   logic                   clean_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= 1'b1;
            else        sync_q <= raw_i;
      end else begin : g_sync_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      end
   endgenerate

   assign sync_out = sync_q[SYNC_STAGES-1];

   // the clean level follows only after FILT_CYCLES differing samples in a row
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         clean_q <= 1'b1;
      end else if (sync_out == clean_q) begin
         cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
         clean_q <= sync_out;
         cnt_q   <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign clean_o = clean_q;

   p_filter_follow_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(clean_q) |-> (clean_q == $past(sync_out)));
endmodule

// File: rtl/tr_regfile.sv
`timescale 1ns/1ps
module tr_regfile #(
   parameter int         NUM_WIPERS = 2,
   parameter logic [7:0] CTRL_ADDR  = 8'h10,
   parameter logic [7:0] CTRL_WMASK = 8'h40,
   parameter logic [7:0] RESET_VAL  = 8'h40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [7:0]              addr,
   input  logic [7:0]              wdata,
   output logic [7:0]              rdata,
   output logic [NUM_WIPERS*8-1:0] wipers_o,
   output logic [7:0]              ctrl_o
);
   initial assert (NUM_WIPERS >= 1 && NUM_WIPERS <= int'(CTRL_ADDR))
      else $error("tr_regfile: tap registers must lie below the control address");

   logic [NUM_WIPERS-1:0][7:0] wip_q;
   logic [7:0]                 ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip_q  <= {NUM_WIPERS{RESET_VAL}};
         ctrl_q <= RESET_VAL & CTRL_WMASK;
      end else if (we) begin
         for (int k = 0; k < NUM_WIPERS; k++)
            if (addr == 8'(k)) wip_q[k] <= wdata;
         if (addr == CTRL_ADDR) ctrl_q <= wdata & CTRL_WMASK;
      end
   end

   always_comb begin
      rdata = 8'h00;
      for (int k = 0; k < NUM_WIPERS; k++)
         if (addr == 8'(k)) rdata = wip_q[k];
      if (addr == CTRL_ADDR) rdata = ctrl_q;
   end

   assign wipers_o = wip_q;
   assign ctrl_o   = ctrl_q;

   p_hold_without_write_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(wipers_o) && $stable(ctrl_o)));

   p_ctrl_fixed_zero_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o & ~CTRL_WMASK) == 8'h00);
endmodule

// File: rtl/tap_reg_i2c_target.sv
`timescale 1ns/1ps
module tap_reg_i2c_target
   import tapreg_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_CYCLES = 10,
   parameter int         BOOT_CYCLES = 64,
   parameter int         NUM_WIPERS  = 2,
   parameter logic [7:0] CTRL_ADDR   = 8'h10,
   parameter logic [7:0] CTRL_WMASK  = 8'h40,
   parameter logic [7:0] RESET_VAL   = 8'h40
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   input  logic [2:0]              strap_i,
   output logic                    sda_pull_o,
   output logic [NUM_WIPERS*8-1:0] wiper_o,
   output logic [7:0]              ctrl_o
);
   localparam int BW = $clog2(BOOT_CYCLES + 2);

   // ---- line conditioning: one filter per bus line ----
   logic [1:0] raw_lines, clean_lines;
   assign raw_lines = {sda_i, scl_i};

   for (genvar gl = 0; gl < 2; gl++) begin : g_line
      tr_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_CYCLES(FILT_CYCLES)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .raw_i  (raw_lines[gl]),
         .clean_o(clean_lines[gl])
      );
   end

   logic scl_f, sda_f, scl_d, sda_d;
   assign scl_f = clean_lines[0];
   assign sda_f = clean_lines[1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
      else        begin scl_d <= scl_f; sda_d <= sda_f; end

   logic bus_start, bus_stop, scl_rise, scl_fall;
   assign bus_start = scl_f & scl_d & sda_d & ~sda_f;
   assign bus_stop  = scl_f & scl_d & ~sda_d & sda_f;
   assign scl_rise  = scl_f & ~scl_d;
   assign scl_fall  = ~scl_f & scl_d;

   // ---- boot hold-off ----
   logic [BW-1:0] boot_q;
   logic          boot_busy;
   assign boot_busy = (boot_q != '0);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         boot_q <= BW'(BOOT_CYCLES);
      else if (boot_busy) boot_q <= boot_q - 1'b1;

   // ---- protocol engine ----
   phase_e     phase_q;
   logic [3:0] bit_q;
   logic [7:0] shift_q, ptr_q;
   logic       rw_q, ack_q, mack_q, pull_q;
   logic       id_match, reg_we;
   logic [7:0] rdata;

   assign id_match = (shift_q[7:1] == {ID_PREFIX, strap_i});
   assign reg_we   = !boot_busy && (phase_q == PH_WRITE) && scl_rise && (bit_q == 4'd8);

   function automatic logic [7:0] step_ptr(input logic [7:0] p);
      if (p == 8'(NUM_WIPERS - 1)) return 8'h00;
      if (p < 8'(NUM_WIPERS - 1))  return p + 8'h01;
      return p;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bit_q   <= '0;
         shift_q <= '0;
         ptr_q   <= '0;
         rw_q    <= 1'b0;
         ack_q   <= 1'b0;
         mack_q  <= 1'b0;
         pull_q  <= 1'b0;
      end else if (boot_busy) begin
         phase_q <= PH_IDLE;
         pull_q  <= 1'b0;
      end else if (bus_start) begin
         phase_q <= PH_ID;
         bit_q   <= '0;
         pull_q  <= 1'b0;
      end else if (bus_stop) begin
         phase_q <= PH_IDLE;
         pull_q  <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
         if (scl_rise) begin
            if (bit_q < 4'd8) shift_q <= {shift_q[6:0], sda_f};
            bit_q <= bit_q + 4'd1;
            if (bit_q == 4'd8) begin
               mack_q <= ~sda_f;
               if (phase_q == PH_ADDR) ptr_q <= shift_q;
               if (phase_q == PH_READ && !sda_f) ptr_q <= step_ptr(ptr_q);
            end
         end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
               unique case (phase_q)
                  PH_ID: begin
                     rw_q   <= shift_q[0];
                     ack_q  <= id_match;
                     pull_q <= id_match;
                  end
                  PH_ADDR, PH_WRITE: pull_q <= 1'b1;
                  default:           pull_q <= 1'b0;
               endcase
            end else if (bit_q == 4'd9) begin
               bit_q <= '0;
               unique case (phase_q)
                  PH_ID: begin
                     if (!ack_q) begin
                        phase_q <= PH_IDLE;
                        pull_q  <= 1'b0;
                     end else if (rw_q) begin
                        phase_q <= PH_READ;
                        shift_q <= rdata;
                        pull_q  <= ~rdata[7];
                     end else begin
                        phase_q <= PH_ADDR;
                        pull_q  <= 1'b0;
                     end
                  end
                  PH_ADDR: begin
                     phase_q <= PH_WRITE;
                     pull_q  <= 1'b0;
                  end
                  PH_WRITE: begin
                     ptr_q  <= step_ptr(ptr_q);
                     pull_q <= 1'b0;
                  end
                  default: begin
                     if (mack_q) begin
                        shift_q <= rdata;
                        pull_q  <= ~rdata[7];
                     end else begin
                        phase_q <= PH_IDLE;
                        pull_q  <= 1'b0;
                     end
                  end
               endcase
            end else if (phase_q == PH_READ) begin
               pull_q <= ~shift_q[7];
            end
         end
      end
   end

   tr_regfile #(
      .NUM_WIPERS(NUM_WIPERS),
      .CTRL_ADDR (CTRL_ADDR),
      .CTRL_WMASK(CTRL_WMASK),
      .RESET_VAL (RESET_VAL)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (reg_we),
      .addr    (ptr_q),
      .wdata   (shift_q),
      .rdata   (rdata),
      .wipers_o(wiper_o),
      .ctrl_o  (ctrl_o)
   );

   assign sda_pull_o = pull_q;

   p_pull_starts_scl_low_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_q) |-> !scl_f);

   p_boot_keeps_idle_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      boot_busy |=> (phase_q == PH_IDLE));

   p_idle_releases_sda_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> !pull_q);
endmodule

// File: tb/test_tap_reg_i2c_target.sv
`timescale 1ns/1ps
module test_tap_reg_i2c_target;
   localparam int         Q     = 25;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [7:0] ID_W  = {4'b1010, STRAP, 1'b0};
   localparam logic [7:0] ID_R  = {4'b1010, STRAP, 1'b1};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        m_scl, m_sda;
   logic        sda_pull;
   logic [15:0] wiper;
   logic [7:0]  ctrl;
   logic        sda_bus;

   always #2.5 clk = ~clk;
   assign sda_bus = m_sda & ~sda_pull;

   tap_reg_i2c_target i_tap_reg_i2c_target (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (m_scl),
      .sda_i     (sda_bus),
      .strap_i   (STRAP),
      .sda_pull_o(sda_pull),
      .wiper_o   (wiper),
      .ctrl_o    (ctrl)
   );

   int          n_chk = 0, n_fail = 0;
   bit          steady = 1'b0, done = 1'b0;
   bit          scl_glitch = 1'b0, sda_glitch = 1'b0;
   logic [7:0]  ew0 = 8'h40, ew1 = 8'h40, ectl = 8'h40;
   logic [15:0] snap_w;
   logic [7:0]  snap_c;
   logic [7:0]  wq[$];

   task automatic chk(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // reference model
   function automatic logic [7:0] exp_read(input logic [7:0] a);
      if (a == 8'h00) return ew0;
      if (a == 8'h01) return ew1;
      if (a == 8'h10) return ectl;
      return 8'h00;
   endfunction

   function automatic logic [7:0] nxt(input logic [7:0] a);
      if (a == 8'h00) return 8'h01;
      if (a == 8'h01) return 8'h00;
      return a;
   endfunction

   function automatic logic [7:0] snap_of(input logic [7:0] a);
      if (a == 8'h00) return snap_w[7:0];
      if (a == 8'h01) return snap_w[15:8];
      if (a == 8'h10) return snap_c;
      return 8'h00;
   endfunction

   task automatic model_write(input logic [7:0] a, input logic [7:0] d);
      if (a == 8'h00) ew0 = d;
      else if (a == 8'h01) ew1 = d;
      else if (a == 8'h10) ectl = d & 8'h40;
   endtask

   // every clock while the bus is quiet, outputs must equal the model
   always @(negedge clk) begin
      if (steady && !done) begin
         chk("R3 tap register 0 vs model", wiper[7:0], ew0);
         chk("R3 tap register 1 vs model", wiper[15:8], ew1);
         chk("R6 control register vs model", ctrl, ectl);
         chk("R10 SDA released while idle", sda_pull, 0);
      end
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start;
      if (m_scl == 1'b0) begin
         m_sda = 1'b1; wt(Q);
         m_scl = 1'b1; wt(Q);
      end
      m_sda = 1'b0; wt(Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic do_stop;
      m_sda = 1'b0; wt(Q);
      m_scl = 1'b1; wt(Q);
      m_sda = 1'b1; wt(2 * Q);
   endtask

   task automatic send_bit(input logic b);
      m_sda = b;
      if (scl_glitch) begin
         wt(4); m_scl = 1'b1; wt(4); m_scl = 1'b0; wt(Q - 8);
         scl_glitch = 1'b0;
      end else wt(Q);
      m_scl = 1'b1;
      if (sda_glitch && b) begin
         wt(Q - 2); m_sda = 1'b0; wt(4); m_sda = 1'b1; wt(Q - 2);
         sda_glitch = 1'b0;
      end else wt(2 * Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; wt(Q);
      m_scl = 1'b1; wt(Q);
      b = sda_bus;
      snap_w = wiper;
      snap_c = ctrl;
      wt(Q);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic give_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~give_ack);
   endtask

   task automatic settle;
      wt(20);
      steady = 1'b1;
      wt(40);
   endtask

   task automatic wr_txn(input logic [7:0] a, input string req);
      logic       ack;
      logic [7:0] p;
      p = a;
      steady = 1'b0;
      do_start;
      send_byte(ID_W, ack);  chk({req, " R2 id ack"}, ack, 1);
      send_byte(a, ack);     chk({req, " R4 address ack"}, ack, 1);
      foreach (wq[i]) begin
         send_byte(wq[i], ack);
         chk({req, " R4 data ack"}, ack, 1);
         model_write(p, wq[i]);
         chk({req, " R3 stored on ninth clock"}, snap_of(p), exp_read(p));
         p = nxt(p);
      end
      do_stop;
      settle;
   endtask

   task automatic rd_txn(input logic [7:0] a, input int n, input string req);
      logic       ack;
      logic [7:0] v, p;
      p = a;
      steady = 1'b0;
      do_start;
      send_byte(ID_W, ack);  chk({req, " R2 id ack"}, ack, 1);
      send_byte(a, ack);     chk({req, " R4 address ack"}, ack, 1);
      do_start;
      send_byte(ID_R, ack);  chk({req, " R8 read id ack"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(v, i < n - 1);
         chk({req, " read data"}, v, exp_read(p));
         p = nxt(p);
      end
      chk({req, " R8 SDA released after NACK"}, sda_pull, 0);
      do_stop;
      settle;
   endtask

   initial begin
      logic ack;
      m_scl = 1'b1;
      m_sda = 1'b1;
      rst_n = 1'b0;
      wt(10);
      chk("R1 tap register 0 reset", wiper[7:0], 8'h40);
      chk("R1 tap register 1 reset", wiper[15:8], 8'h40);
      chk("R1 control register reset", ctrl, 8'h40);
      chk("R1 SDA released in reset", sda_pull, 0);
      rst_n = 1'b1;

      // R11: START during the boot window is ignored, and so is its transfer
      wt(3);
      do_start;
      send_byte(ID_W, ack);  chk("R11 no id ack during boot", ack, 0);
      send_byte(8'h00, ack); chk("R11 no address ack", ack, 0);
      send_byte(8'h11, ack); chk("R11 no data ack", ack, 0);
      do_stop;
      settle;

      // R3: single writes
      wq = '{8'h23};  wr_txn(8'h00, "R3 write tap 0");
      wq = '{8'h7F};  wr_txn(8'h01, "R3 write tap 1");

      // R5: stepping with wrap
      wq = '{8'h05, 8'h06, 8'h07}; wr_txn(8'h00, "R5 run from 0");
      wq = '{8'h31, 8'h42};        wr_txn(8'h01, "R5 run from 1");

      // R6: control mask
      wq = '{8'hFF};  wr_txn(8'h10, "R6 control FF");
      rd_txn(8'h10, 1, "R6 control read");
      wq = '{8'h00};  wr_txn(8'h10, "R6 control 00");
      rd_txn(8'h10, 1, "R6 control read zero");
      wq = '{8'hBF, 8'h40}; wr_txn(8'h10, "R6 control no step");

      // R7: unmapped
      wq = '{8'h99};  wr_txn(8'h05, "R7 unmapped write");
      rd_txn(8'h05, 1, "R7 unmapped read");

      // R8: random and sequential reads
      rd_txn(8'h01, 3, "R8 sequential read");
      rd_txn(8'h00, 1, "R8 random read");

      // R2: wrong strap, then wrong prefix, then a good START recovers
      steady = 1'b0;
      do_start;
      send_byte({4'b1010, STRAP ^ 3'b010, 1'b0}, ack); chk("R2 wrong strap no ack", ack, 0);
      send_byte(8'h00, ack); chk("R2 ignored address", ack, 0);
      send_byte(8'h77, ack); chk("R2 ignored data", ack, 0);
      do_start;
      send_byte({4'b1011, STRAP, 1'b0}, ack); chk("R2 wrong prefix no ack", ack, 0);
      send_byte(8'h01, ack); chk("R2 ignored address 2", ack, 0);
      do_start;
      send_byte(ID_W, ack);  chk("R2 good id after START", ack, 1);
      send_byte(8'h01, ack); chk("R4 address ack after recovery", ack, 1);
      send_byte(8'h3C, ack); chk("R4 data ack after recovery", ack, 1);
      model_write(8'h01, 8'h3C);
      do_stop;
      settle;

      // R10: bytes without START after a STOP
      steady = 1'b0;
      m_scl = 1'b0; wt(Q);
      send_byte(ID_W, ack);  chk("R10 no ack without START", ack, 0);
      send_byte(8'h00, ack); chk("R10 no address ack", ack, 0);
      send_byte(8'h5A, ack); chk("R10 no data ack", ack, 0);
      do_stop;
      wt(20);
      chk("R10 tap 0 unchanged", wiper[7:0], ew0);
      settle;

      // R9: short glitches on SCL and SDA
      scl_glitch = 1'b1;
      wq = '{8'hA6};  wr_txn(8'h00, "R9 SCL glitch");
      sda_glitch = 1'b1;
      wq = '{8'h5D};  wr_txn(8'h01, "R9 SDA glitch");
      rd_txn(8'h00, 2, "R9 read after glitches");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired, actual=hung expected=complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule